// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a successive-approximation analog-to-digital conversion. A falling edge on the convert-start input starts a bit-by-bit binary search, most significant bit first. The search word goes straight to an external DAC. On every step the block takes a one-bit comparator verdict. It then decides the bit under test and arms the next one. The DAC, the comparator and all analog scaling stay outside the block. The comparator is seen only as an input bit that is already synchronous to the system clock.

The word is kept in complementary (negative-true) form throughout. A bit that is tried or kept reads 0, and a rejected or untried bit reads 1. The same register drives the DAC and the parallel result.

While a conversion runs, a busy flag is high and a gated conversion clock pulses once for each step. The flag falls only after the last decision, so its falling edge can be used to capture the result. A 3-bit resolution code, taken only at the start, can stop the search early after 8, 10, 12, 13, 14 or 15 bits.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and after its release, busy_o is 0, data_o is all ones and gclk_o stays low until a conversion starts.
- R2: A conversion starts only on a falling edge of start_i (1 at one clock edge, 0 at the next) while idle. busy_o is high after the clock edge at which the falling edge is seen. Holding start_i high or raising it starts nothing.
- R3: At the end of a conversion, data_o is the bitwise complement of the input's true code for the converted bits. cmp_i = 1 means the analog input is at or above the trial value, so the bit under test is kept (stays 0). cmp_i = 0 rejects the bit (it becomes 1).
- R4: On the first busy clock, data_o is all ones. After the next clock, bit NBITS-1 (the MSB) is 0 and all lower bits are 1. Each later step decides one bit and clears the next lower bit.
- R5: busy_o stays high for exactly N+1 clock cycles, where N is the selected resolution.
- R6: gclk_o gives exactly N+1 rising edges per conversion, one for each step. It is held low while idle.
- R7: res_sel_i selects N as follows: 0→16, 1→15, 2→14, 3→13, 4→12, 5→10, 6→8, 7→16 (for NBITS=16, N = NBITS minus 0,1,2,3,4,6,8,0). Bits below the N converted bits stay 1.
- R8: A falling edge of start_i while busy_o is high is ignored. The running conversion keeps its length and result.
- R9: res_sel_i is sampled only at the start. Changing it during a conversion does not change that conversion's length or result.
- R10: After busy_o falls, data_o holds its value until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one conversion step per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert-start pulse; its falling edge starts a conversion |
| res_sel_i | input | 3 | Resolution code, sampled at start |
| cmp_i | input | 1 | Comparator verdict; 1 = input at or above trial value |
| busy_o | output | 1 | High while a conversion is in progress |
| gclk_o | output | 1 | Gated conversion clock, pulses only while busy |
| data_o | output | NBITS | Trial word to the DAC and complementary parallel result |

## Verification
The bench closes the loop with a model comparator that compares a chosen input code against the complement of data_o. The inputs include all zeros, all ones, the two words on either side of midscale and irregular bit mixes. These separate a stuck keep decision, a stuck reject decision and an off-by-one in the bit index. Every resolution code is run, so the length mapping, the busy and clock-pulse counts and the all-ones tail of a short conversion are each checked separately. Directed runs then disturb start_i and res_sel_i during a conversion and hold start_i high while idle, to show that those inputs are ignored at those times.

// File: rtl/sar_pkg.sv
package sar_pkg;

   // Resolution code to number of converted bits.
   function automatic int unsigned res_len(input logic [2:0] code, input int unsigned nb);
      case (code)
         3'd1:    res_len = nb - 1;
         3'd2:    res_len = nb - 2;
         3'd3:    res_len = nb - 3;
         3'd4:    res_len = nb - 4;
         3'd5:    res_len = nb - 6;
         3'd6:    res_len = nb - 8;
         default: res_len = nb;
      endcase
   endfunction

endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic fall_o
);
   logic start_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_q <= 1'b0;
      else         start_q <= start_i;
   end

   assign fall_o = start_q & ~start_i;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
   parameter int unsigned NBITS = 16,
   localparam int unsigned SW   = $clog2(NBITS + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          fall_i,
   input  logic [2:0]    res_sel_i,
   output logic          go_o,
   output logic          busy_o,
   output logic [SW-1:0] step_o,
   output logic [SW-1:0] nlen_o
);
   import sar_pkg::*;

   assign go_o = fall_i & ~busy_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         step_o <= '0;
         nlen_o <= SW'(NBITS);
      end else if (go_o) begin
         busy_o <= 1'b1;
         step_o <= '0;
         nlen_o <= SW'(res_len(res_sel_i, NBITS));
      end else if (busy_o) begin
         if (step_o == nlen_o) busy_o <= 1'b0;
         else                  step_o <= step_o + 1'b1;
      end
   end
endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
   parameter int unsigned NBITS    = 16,
   parameter bit          CMP_HIGH = 1'b1,
   localparam int unsigned SW      = $clog2(NBITS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic             busy_i,
   input  logic [SW-1:0]    step_i,
   input  logic [SW-1:0]    nlen_i,
   input  logic             cmp_i,
   output logic [NBITS-1:0] word_o
);
   logic keep;

   generate
      if (CMP_HIGH) begin : g_cmp_pos
         assign keep = cmp_i;
      end else begin : g_cmp_neg
         assign keep = ~cmp_i;
      end
   endgenerate

   // Bit number b (1 = MSB) sits at index NBITS-b.
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      localparam int unsigned B = NBITS - i;
      logic arm, decide;
      assign arm    = busy_i && (step_i == SW'(B - 1)) && (SW'(B) <= nlen_i);
      assign decide = busy_i && (step_i == SW'(B));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     word_o[i] <= 1'b1;
         else if (go_i)   word_o[i] <= 1'b1;
         else if (decide) word_o[i] <= ~keep;
         else if (arm)    word_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sar_clk_gate.sv
module sar_clk_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic gclk_o
);
   logic en_n;

   // Enable changes only while clk_i is low, so the gated output never glitches.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_n <= 1'b0;
      else         en_n <= en_i;
   end

   assign gclk_o = clk_i & en_n;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int unsigned NBITS    = 16,
   parameter bit          CMP_HIGH = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [2:0]       res_sel_i,
   input  logic             cmp_i,
   output logic             busy_o,
   output logic             gclk_o,
   output logic [NBITS-1:0] data_o
);
   localparam int unsigned SW = $clog2(NBITS + 1);

   generate
      if (NBITS < 9 || NBITS > 64) begin : g_bad_width
         $error("sar_seq: NBITS must be within 9..64");
      end
   endgenerate

   logic          fall, go;
   logic [SW-1:0] step, nlen;

   sar_start_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .fall_o  (fall)
   );

   sar_ctrl #(.NBITS(NBITS)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fall_i    (fall),
      .res_sel_i (res_sel_i),
      .go_o      (go),
      .busy_o    (busy_o),
      .step_o    (step),
      .nlen_o    (nlen)
   );

   sar_bits #(.NBITS(NBITS), .CMP_HIGH(CMP_HIGH)) u_bits (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (go),
      .busy_i (busy_o),
      .step_i (step),
      .nlen_i (nlen),
      .cmp_i  (cmp_i),
      .word_o (data_o)
   );

   sar_clk_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (busy_o),
      .gclk_o (gclk_o)
   );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int unsigned NBITS = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             busy_o,
   input logic [NBITS-1:0] data_o
);
   localparam int unsigned CW = $clog2(NBITS + 2);
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(start_i) && !busy_o) |=> busy_o); // R2

   AST_FIRST_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (data_o == {NBITS{1'b1}})); // R4

   AST_MSB_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |=> (data_o == {1'b0, {(NBITS-1){1'b1}}})); // R4

   AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (run_cnt <= CW'(NBITS))); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |=> ($stable(data_o) || busy_o)); // R10
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .busy_o  (busy_o),
   .data_o  (data_o)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
   localparam int NB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    res_sel = 3'd0;
   logic          busy, gclk;
   logic [NB-1:0] data;
   logic [NB-1:0] ana = '0;
   logic          cmp;
   int            checks = 0;
   int            errors = 0;
   int            gcnt = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   // Model comparator: true trial value is the complement of data.
   assign cmp = (ana >= ~data);

   always @(posedge gclk) gcnt++;

   sar_seq #(.NBITS(NB)) uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .res_sel_i (res_sel),
      .cmp_i     (cmp),
      .busy_o    (busy),
      .gclk_o    (gclk),
      .data_o    (data)
   );

   typedef struct packed {
      logic [15:0] code;
      logic [2:0]  sel;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{16'h0000, 3'd0}, '{16'hFFFF, 3'd0}, '{16'h8000, 3'd0}, '{16'h7FFF, 3'd0},
      '{16'hA5C3, 3'd0}, '{16'h1234, 3'd6}, '{16'hBEEF, 3'd5}, '{16'h5555, 3'd4},
      '{16'hC3A9, 3'd3}, '{16'h2F71, 3'd2}, '{16'hE00D, 3'd1}, '{16'h6B2E, 3'd7}
   };

   function automatic int exp_len(input logic [2:0] s);
      case (s)
         3'd1: return 15;
         3'd2: return 14;
         3'd3: return 13;
         3'd4: return 12;
         3'd5: return 10;
         3'd6: return 8;
         default: return 16;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // mode: 0 plain, 1 extra start edge mid-run, 2 res_sel change mid-run
   task automatic run_conv(input logic [15:0] a, input logic [2:0] sel, input int mode);
      int n, bcnt;
      logic [15:0] mask, expw, first_w, second_w;
      n    = exp_len(sel);
      mask = 16'hFFFF << (16 - n);
      expw = ~(a & mask);
      @(negedge clk);
      ana = a; res_sel = sel; start = 1'b1;
      @(negedge clk);
      start = 1'b0; gcnt = 0; bcnt = 0;
      first_w = '0; second_w = '0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (busy) begin
            bcnt++;
            if (bcnt == 1) first_w = data;
            if (bcnt == 2) second_w = data;
            if (mode == 1 && bcnt == 3) start = 1'b1;
            if (mode == 1 && bcnt == 4) start = 1'b0;
            if (mode == 2 && bcnt == 3) res_sel = (sel == 3'd6) ? 3'd0 : 3'd6;
         end else if (bcnt > 0) begin
            break;
         end
      end
      check(first_w == 16'hFFFF, "R4 first busy word", first_w, 16'hFFFF);
      check(second_w == 16'h7FFF, "R4 MSB trial word", second_w, 16'h7FFF);
      check(bcnt == n + 1, (mode == 2) ? "R9 busy length" : "R5 busy length", bcnt, n + 1);
      check(gcnt == n + 1, "R6 gated clock pulses", gcnt, n + 1);
      check(data == expw, (mode == 1) ? "R8 result" : (mode == 2) ? "R9 result" : "R3 R7 result", data, expw);
      ana = ~a;
      repeat (3) @(negedge clk);
      check(data == expw, "R10 result held", data, expw);
      check(gcnt == n + 1 && !gclk, "R6 gated clock idle", gcnt, n + 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy in reset", busy, 0);
      check(data == 16'hFFFF, "R1 data in reset", data, 16'hFFFF);
      check(gcnt == 0, "R1 gclk in reset", gcnt, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && data == 16'hFFFF, "R1 idle after reset", data, 16'hFFFF);

      foreach (VEC[i]) run_conv(VEC[i].code, VEC[i].sel, 0);

      // R2: raising and holding start does not begin a conversion
      @(negedge clk); start = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check(busy == 1'b0, "R2 no start while high", busy, 0);
      end
      check(gcnt == 17, "R2 gclk quiet while start high", gcnt, 17);
      run_conv(16'h3C3C, 3'd0, 0);

      // R8: extra falling edge while busy is ignored
      run_conv(16'h9A6B, 3'd4, 1);
      // R9: resolution change mid-run has no effect
      run_conv(16'h4D21, 3'd6, 2);
      run_conv(16'hF0F0, 3'd0, 2);
      // R7: short tail stays all ones
      run_conv(16'hFFFF, 3'd6, 0);
      check(data[7:0] == 8'hFF, "R7 unconverted bits", data[7:0], 8'hFF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule